// File: doc/BRIEF.md
# Write Enable and Block Protection Guard

This block decides whether a command that changes a serial memory may proceed. A front end decodes the serial command stream and hands over one event per command, at the moment chip select rises. Each event carries a flag that marks the deselect as clean, meaning it came right after a whole command. The block keeps the write enable latch and the protection fields of the status register, and it computes the status byte for status reads. For every event it returns a one-cycle grant bit. The write engine acts only on a granted command.

The array is split into four equal sectors. A two-bit block-protect field fences off none of them, the top quarter, the top half, or the whole array. Page erases, sector erases and array writes aimed into the fenced range are refused. A chip erase is refused while any protection is active. A protect-enable bit together with a low write-protect pin locks the status register. While the write engine reports a cycle in progress, the block ignores every event, and the status byte shows the busy state live.

Top module: `wprot_guard`

## Requirements
- R1: After reset, `status_o` is 8'h00 (with `wip_in` low) and `grant_o` is all zero.
- R2: A set-enable event (kind 0) with `evt_clean` high sets the enable bit `status_o[1]` from the next cycle on. The same event with `evt_clean` low leaves the bit unchanged. An event with `evt_clean` low is never granted.
- R3: While the enable bit is 0, status write (kind 2), array write (3), page erase (4), sector erase (5) and chip erase (6) are refused.
- R4: A granted clear-enable (1), status write, array write, page erase, sector erase or chip erase leaves the enable bit at 0 in the cycle its grant shows. A refused event leaves the bit unchanged.
- R5: With protect field P = `status_o[3:2]`, an array write, page erase or sector erase is refused when its address is in the fenced range: P=0 fences nothing, P=1 fences addresses with the top two bits 11, P=2 fences addresses with the top bit 1, P=3 fences every address.
- R6: A chip erase is refused whenever P is nonzero.
- R7: A status write is refused when `status_o[7]` is 1 and `wp_pin_n` is 0. When granted, it loads `evt_wdata[7]` into bit 7 and `evt_wdata[3:2]` into bits 3:2.
- R8: `status_o[0]` follows `wip_in` in the same cycle. While `wip_in` is high, no event is granted and bits 7:1 of the status do not change.
- R9: The status byte layout is protect-enable at bit 7, P at bits 3:2, enable at bit 1 and in-progress at bit 0. Bits 6:4 read 0.
- R10: `grant_o` is registered. For an event sampled at a clock edge, bit `evt_kind` of `grant_o` is 1 for the following cycle if the event is granted. No other bit is set. Kind 7 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle strobe: a command ended at deselect |
| evt_clean | input | 1 | The deselect came right after a complete command |
| evt_kind | input | 3 | 0 set-enable, 1 clear-enable, 2 status write, 3 array write, 4 page erase, 5 sector erase, 6 chip erase |
| evt_addr | input | ADDR_W | Target address of the command |
| evt_wdata | input | 8 | Data byte of a status write |
| wp_pin_n | input | 1 | Write-protect pin, active low |
| wip_in | input | 1 | Write cycle in progress, from the write engine |
| status_o | output | 8 | Status byte for status reads |
| grant_o | output | 7 | One-hot grant, bit index equals event kind |

## Verification
On every cycle, the assertions check that the grant is one-hot. They also check that nothing is granted while busy or without the enable latch, that no chip erase is granted under protection, and that the latch reads zero whenever a modifying grant appears. Only the bench's scenarios can show the actual protection boundaries (for example 16'hBFFF against 16'hC000). The same goes for the status-lock interplay of the pin with the protect-enable bit, an unclean deselect leaving the latch alone, and the exact bit layout of the status byte after a load.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
   typedef enum logic [2:0] {
      EV_SET_EN  = 3'd0,
      EV_CLR_EN  = 3'd1,
      EV_STAT_WR = 3'd2,
      EV_ARR_WR  = 3'd3,
      EV_PAGE_ER = 3'd4,
      EV_SECT_ER = 3'd5,
      EV_CHIP_ER = 3'd6,
      EV_NONE    = 3'd7
   } evt_kind_e;

   localparam int unsigned NUM_KINDS = 7;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned BIT_PEN   = 7;
   localparam int unsigned BIT_BP_HI = 3;
   localparam int unsigned BIT_BP_LO = 2;
   localparam int unsigned BIT_WEL   = 1;
   localparam int unsigned BIT_WIP   = 0;
endpackage

// File: rtl/wprot_range.sv
module wprot_range #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [1:0]        bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic              any_o
);
   localparam int unsigned TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad
         $error("wprot_range: ADDR_W must lie in 2..32");
      end
   endgenerate

   logic [1:0] quarter;
   assign quarter = addr_i[TOP -: 2];

   always_comb begin
      unique case (bp_i)
         2'b00:   hit_o = 1'b0;
         2'b01:   hit_o = (quarter == 2'b11);
         2'b10:   hit_o = quarter[1];
         default: hit_o = 1'b1;
      endcase
   end

   assign any_o = |bp_i;

   logic unused_low;
   assign unused_low = ^addr_i;
endmodule

// File: rtl/wprot_status_reg.sv
module wprot_status_reg
   import wprot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [STAT_W-1:0] wdata_i,
   output logic              pen_o,
   output logic [1:0]        bp_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pen_o <= 1'b0;
         bp_o  <= 2'b00;
      end else if (load_i) begin
         pen_o <= wdata_i[BIT_PEN];
         bp_o  <= wdata_i[BIT_BP_HI:BIT_BP_LO];
      end
   end

   logic unused_bits;
   assign unused_bits = ^{wdata_i[6:4], wdata_i[1:0]};
endmodule

// File: rtl/wprot_latch.sv
module wprot_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic wel_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wel_o <= 1'b0;
      else if (clr_i) wel_o <= 1'b0;
      else if (set_i) wel_o <= 1'b1;
   end

   default clocking cb @(posedge clk); endclocking

   assert_set_clr_excl_R4: assert property (disable iff (!rst_n)
      !(set_i && clr_i));
endmodule

// File: rtl/wprot_arbiter.sv
module wprot_arbiter
   import wprot_pkg::*;
(
   input  logic                 valid_i,
   input  logic                 clean_i,
   input  logic [2:0]           kind_i,
   input  logic                 busy_i,
   input  logic                 wel_i,
   input  logic                 pen_i,
   input  logic                 wp_n_i,
   input  logic                 hit_i,
   input  logic                 any_i,
   output logic [NUM_KINDS-1:0] grant_o,
   output logic                 set_wel_o,
   output logic                 clr_wel_o,
   output logic                 load_o
);
   evt_kind_e kind;
   logic      base_ok;
   logic      ok;

   assign kind    = evt_kind_e'(kind_i);
   assign base_ok = valid_i && clean_i && !busy_i;

   always_comb begin
      unique case (kind)
         EV_SET_EN, EV_CLR_EN:            ok = base_ok;
         EV_STAT_WR:                      ok = base_ok && wel_i && !(pen_i && !wp_n_i);
         EV_ARR_WR, EV_PAGE_ER, EV_SECT_ER: ok = base_ok && wel_i && !hit_i;
         EV_CHIP_ER:                      ok = base_ok && wel_i && !any_i;
         default:                         ok = 1'b0;
      endcase
   end

   always_comb begin
      grant_o = '0;
      for (int k = 0; k < NUM_KINDS; k++) begin
         if (ok && kind_i == 3'(k)) grant_o[k] = 1'b1;
      end
   end

   assign set_wel_o = ok && (kind == EV_SET_EN);
   assign clr_wel_o = ok && (kind != EV_SET_EN);
   assign load_o    = ok && (kind == EV_STAT_WR);
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
   import wprot_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter bit          WIP_SYNC = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_valid,
   input  logic                 evt_clean,
   input  logic [2:0]           evt_kind,
   input  logic [ADDR_W-1:0]    evt_addr,
   input  logic [7:0]           evt_wdata,
   input  logic                 wp_pin_n,
   input  logic                 wip_in,
   output logic [7:0]           status_o,
   output logic [6:0]           grant_o
);
   generate
      if (NUM_KINDS != 7) begin : g_kinds_bad
         $error("wprot_guard: grant width mismatch");
      end
   endgenerate

   logic                 wip_eff;
   logic                 wel;
   logic                 pen;
   logic [1:0]           bp;
   logic                 hit;
   logic                 any_prot;
   logic [NUM_KINDS-1:0] grant_nx;
   logic                 set_wel;
   logic                 clr_wel;
   logic                 load_st;

   generate
      if (WIP_SYNC) begin : g_wip_reg
         logic wip_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wip_q <= 1'b0;
            else        wip_q <= wip_in;
         end
         assign wip_eff = wip_q | wip_in;
      end else begin : g_wip_comb
         assign wip_eff = wip_in;
      end
   endgenerate

   wprot_range #(.ADDR_W(ADDR_W)) range_i (
      .bp_i   (bp),
      .addr_i (evt_addr),
      .hit_o  (hit),
      .any_o  (any_prot)
   );

   wprot_arbiter arb_i (
      .valid_i   (evt_valid),
      .clean_i   (evt_clean),
      .kind_i    (evt_kind),
      .busy_i    (wip_eff),
      .wel_i     (wel),
      .pen_i     (pen),
      .wp_n_i    (wp_pin_n),
      .hit_i     (hit),
      .any_i     (any_prot),
      .grant_o   (grant_nx),
      .set_wel_o (set_wel),
      .clr_wel_o (clr_wel),
      .load_o    (load_st)
   );

   wprot_latch latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_wel),
      .clr_i (clr_wel),
      .wel_o (wel)
   );

   wprot_status_reg stat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_st),
      .wdata_i (evt_wdata),
      .pen_o   (pen),
      .bp_o    (bp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_o <= '0;
      else        grant_o <= grant_nx;
   end

   always_comb begin
      status_o            = '0;
      status_o[BIT_PEN]   = pen;
      status_o[BIT_BP_HI] = bp[1];
      status_o[BIT_BP_LO] = bp[0];
      status_o[BIT_WEL]   = wel;
      status_o[BIT_WIP]   = wip_eff;
   end

   default clocking cb @(posedge clk); endclocking

   assert_grant_onehot_R10: assert property (disable iff (!rst_n)
      $onehot0(grant_o));

   assert_busy_blocks_R8: assert property (disable iff (!rst_n)
      (evt_valid && wip_in) |=> (grant_o == '0 && $stable(status_o[7:1])));

   assert_need_latch_R3: assert property (disable iff (!rst_n)
      (evt_valid && !status_o[1] && evt_kind >= 3'd2) |=> (grant_o == '0));

   assert_chip_fenced_R6: assert property (disable iff (!rst_n)
      (evt_valid && evt_kind == 3'd6 && status_o[3:2] != 2'b00) |=> !grant_o[6]);

   assert_latch_drops_R4: assert property (disable iff (!rst_n)
      (|grant_o[6:1]) |-> !status_o[1]);

   assert_unclean_ignored_R2: assert property (disable iff (!rst_n)
      (evt_valid && !evt_clean) |=> (grant_o == '0));
endmodule

// File: tb/wprot_guard_tb_top.sv
`timescale 1ns/1ps
module wprot_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic        evt_clean = 1'b0;
   logic [2:0]  evt_kind = 3'd7;
   logic [15:0] evt_addr = '0;
   logic [7:0]  evt_wdata = '0;
   logic        wp_pin_n = 1'b1;
   logic        wip_in = 1'b0;
   logic [7:0]  status_o;
   logic [6:0]  grant_o;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   bit       m_wel = 0;
   bit       m_pen = 0;
   bit [1:0] m_bp  = 0;

   always #4 clk = ~clk;

   wprot_guard dut_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_clean(evt_clean),
      .evt_kind(evt_kind), .evt_addr(evt_addr), .evt_wdata(evt_wdata),
      .wp_pin_n(wp_pin_n), .wip_in(wip_in), .status_o(status_o), .grant_o(grant_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit fenced(input bit [1:0] bp, input bit [15:0] a);
      case (bp)
         2'd0: return 1'b0;
         2'd1: return a >= 16'hC000;
         2'd2: return a >= 16'h8000;
         default: return 1'b1;
      endcase
   endfunction

   function automatic bit [7:0] exp_status(input bit busy);
      return {m_pen, 3'b000, m_bp, m_wel, busy};
   endfunction

   function automatic string tag_of(input int k, input bit cl, input bit busy);
      if (busy) return "R8";
      if (!cl)  return "R2";
      if (k == 7) return "R10";
      if (k >= 2 && !m_wel) return "R3";
      case (k)
         0: return "R2";
         1: return "R4";
         2: return "R7";
         6: return "R6";
         default: return "R5";
      endcase
   endfunction

   task automatic issue(input int k, input bit cl, input bit [15:0] a, input bit [7:0] d,
                        input bit wpn, input bit busy);
      bit     ok;
      string  tag;
      tag = tag_of(k, cl, busy);
      ok = cl && !busy;
      case (k)
         0, 1: ;
         2: ok = ok && m_wel && !(m_pen && !wpn);
         3, 4, 5: ok = ok && m_wel && !fenced(m_bp, a);
         6: ok = ok && m_wel && (m_bp == 0);
         default: ok = 0;
      endcase
      @(negedge clk);
      evt_valid = 1; evt_clean = cl; evt_kind = 3'(k); evt_addr = a;
      evt_wdata = d; wp_pin_n = wpn; wip_in = busy;
      @(negedge clk);
      evt_valid = 0;
      if (ok) begin
         if (k == 0) m_wel = 1; else m_wel = 0;
         if (k == 2) begin m_pen = d[7]; m_bp = d[3:2]; end
      end
      check({tag, " grant"}, 32'(grant_o), ok ? (32'd1 << k) : 32'd0);
      check({tag, " status"}, 32'(status_o), 32'(exp_status(busy)));
      wip_in = 0;
   endtask

   initial begin
      process::self().srandom(32'd1234);
      #1;
      check("R1 status", 32'(status_o), 32'h00);
      check("R1 grant", 32'(grant_o), 32'h00);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 status after release", 32'(status_o), 32'h00);

      issue(3, 1, 16'h0010, 8'h00, 1, 0);                 // R3 write without latch
      issue(0, 0, 16'h0000, 8'h00, 1, 0);                 // R2 unclean set
      check("R2 latch stays clear", 32'(status_o[1]), 32'd0);
      issue(0, 1, 16'h0000, 8'h00, 1, 0);                 // R2 clean set
      check("R2 latch set", 32'(status_o[1]), 32'd1);
      issue(2, 1, 16'h0000, 8'hFF, 1, 0);                 // R7 load
      check("R9 layout", 32'(status_o), 32'h8C);
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(2, 1, 16'h0000, 8'h00, 0, 0);                 // R7 locked by pin
      check("R4 refused keeps latch", 32'(status_o), 32'h8E);
      issue(2, 1, 16'h0000, 8'h04, 1, 0);                 // bp = quarter
      check("R7 quarter", 32'(status_o), 32'h04);
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(3, 1, 16'hC000, 8'h00, 1, 0);                 // R5 fenced
      issue(5, 1, 16'hFFFF, 8'h00, 1, 0);                 // R5 fenced
      issue(4, 1, 16'hBFFF, 8'h00, 1, 0);                 // R5 open
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(6, 1, 16'h0000, 8'h00, 1, 0);                 // R6 refused
      issue(2, 1, 16'h0000, 8'h08, 1, 0);                 // half
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(3, 1, 16'h8000, 8'h00, 1, 0);                 // R5 half fenced
      issue(3, 1, 16'h7FFF, 8'h00, 1, 0);                 // R5 half open
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(2, 1, 16'h0000, 8'h00, 1, 0);
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(6, 1, 16'h0000, 8'h00, 1, 0);                 // R6 granted
      issue(0, 1, 16'h0000, 8'h00, 1, 0);
      issue(1, 1, 16'h0000, 8'h00, 1, 1);                 // R8 busy ignores
      check("R8 latch kept", 32'(status_o[1]), 32'd1);
      issue(7, 1, 16'h0000, 8'h00, 1, 0);                 // R10 kind 7
      @(negedge clk); wip_in = 1; #1;
      check("R8 mirror", 32'(status_o[0]), 32'd1);
      wip_in = 0; #1;
      check("R8 mirror low", 32'(status_o[0]), 32'd0);

      for (int i = 0; i < 600; i++) begin
         int  k;
         bit  cl, busy, wpn;
         k    = ($urandom % 3 == 0) ? 0 : int'($urandom % 8);
         cl   = ($urandom % 5) != 0;
         busy = ($urandom % 7) == 0;
         wpn  = $urandom % 2;
         issue(k, cl, 16'($urandom), 8'($urandom), wpn, busy);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule